// File: doc/BRIEF.md
# Two-Wire Slave Register Access Controller

This block sits on a two-wire serial bus as a slave. An external master uses it to read and write a 16-bit register space inside the chip. Both bus lines are oversampled by the system clock through synchronizer flops. The block then detects start, repeated start and stop conditions, and moves bytes MSB first. It never drives the data line high. It only enables an open-drain pull-down.

A transfer begins with a device byte. Its upper seven bits carry the device address and its lowest bit the direction. A strap input chooses between two unrelated device addresses. On a write, the master sends a two-byte register pointer and then any number of 16-bit words, each as a byte pair. Every complete word produces a single write strobe on a simple register port, and the pointer then advances.

On a read, the pointer comes from an earlier write, usually the one just before a repeated start. The block fetches the word at that pointer and sends it high byte first. It fetches the next word each time the master acknowledges a low byte. A not-acknowledge ends the read.

Top module: `tws_reg_slave`

## Requirements
- R1: After reset the data line is released (`sda_oe` = 0), and `reg_wr` and `reg_rd` are low.
- R2: Start and stop are recognised as follows, with the clock high:
  - A falling data line while the clock is high is a start. A start at any point, including one without a preceding stop, restarts reception, and the next byte is a device byte.
  - A rising data line while the clock is high is a stop. A stop releases the data line.
- R3: In the device byte, bits [7:1] are the address and bit 0 is the direction (0 write, 1 read). With `addr_sel` = 0 the block answers device bytes 0x90 and 0x91. With `addr_sel` = 1 it answers 0xBA and 0xBB. Every other address is left unacknowledged.
- R4: After an address mismatch the block leaves the data line released. It acknowledges nothing until the next start condition.
- R5: Every accepted received byte is acknowledged by pulling the data line low during the ninth clock period.
- R6: In a write, the block takes bytes in this order:
  - The pointer arrives high byte first, then low byte.
  - Each word arrives high byte first.
  - When a word's low byte has been acknowledged, `reg_wr` pulses for one cycle with `reg_addr` equal to the pointer and `reg_wdata` equal to the word.
  - The pointer then increments and wraps from 0xFFFF to 0x0000.
- R7: A transfer that ends with an incomplete word (only its high byte) produces no write strobe.
- R8: In a read, `reg_rd` pulses for one cycle during the device-byte acknowledge, and `reg_rdata` is taken in that cycle. The word's high byte is then sent before its low byte, MSB first.
- R9: When the master acknowledges a low byte, the pointer increments and a new `reg_rd` fetches the next word. A not-acknowledge ends the read without incrementing the pointer.
- R10: `reg_wr` and `reg_rd` are never high together, and each is high for a single cycle at a time.
- R11: `sda_oe` changes only while the synchronized clock is low, except when a start or stop releases it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen at the pin |
| sda_i | input | 1 | Bus data line as seen at the pin |
| addr_sel | input | 1 | Strap choosing the device address (0: 0x48, 1: 0x5D) |
| sda_oe | output | 1 | Pull-down enable for the data line |
| reg_addr | output | 16 | Register pointer presented to the register port |
| reg_wdata | output | 16 | Word to be written |
| reg_wr | output | 1 | One-cycle write strobe |
| reg_rd | output | 1 | One-cycle read strobe |
| reg_rdata | input | 16 | Register contents, valid in the cycle `reg_rd` is high |

## Verification
The assertions on the timing of `sda_oe` rest on an assumption about the master: it holds each clock phase for several system clocks, longer than the synchronizer latency. They also assume it never issues a start or stop while the slave is driving. The same rules let the write-strobe check treat the cycle after a strobe as free of bus events. The bench master keeps every quarter bit at six system clocks. It changes data only a quarter bit after the clock has fallen, and it places starts and stops only where the slave has already released the line.

// File: rtl/tws_pkg.sv
package tws_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_RX,
    ST_ACK,
    ST_COMMIT,
    ST_FETCH,
    ST_TX,
    ST_MACK,
    ST_HOLD,
    ST_IGNORE
  } tws_state_t;

  // Does the received 7-bit address equal the one the strap selects?
  function automatic logic dev_match(input logic [6:0] rx_addr, input logic sel,
                                     input logic [6:0] addr0, input logic [6:0] addr1);
    return rx_addr == (sel ? addr1 : addr0);
  endfunction

  // Next pointer value, modulo 2^16.
  function automatic logic [15:0] ptr_step(input logic [15:0] p);
    return p + 16'd1;
  endfunction

  // Pick a byte of a word: lo=0 gives the upper byte.
  function automatic logic [7:0] word_byte(input logic [15:0] w, input logic lo);
    return lo ? w[7:0] : w[15:8];
  endfunction

endpackage

// File: rtl/tws_line_sync.sv
module tws_line_sync #(
  parameter int STAGES = 2,
  parameter int W      = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  // Idle bus lines are high, so the chain resets to ones.
  logic [STAGES-1:0][W-1:0] stg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg <= '1;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/tws_bus_cond.sv
module tws_bus_cond (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_s,
  input  logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_ev,
  output logic stop_ev
);
  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_s;
      sda_q <= sda_s;
    end
  end

  assign scl_rise = scl_s & ~scl_q;
  assign scl_fall = ~scl_s & scl_q;
  // Data edges count as conditions only while the clock stays high.
  assign start_ev = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_ev  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/tws_slave_ctrl.sv
module tws_slave_ctrl
  import tws_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR_0 = 7'h48,
  parameter logic [6:0] DEV_ADDR_1 = 7'h5D,
  parameter int         WORD_W     = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sda_s,
  input  logic              ev_scl_rise,
  input  logic              ev_scl_fall,
  input  logic              ev_start,
  input  logic              ev_stop,
  input  logic              addr_sel,
  input  logic [WORD_W-1:0] reg_rdata,
  output logic              sda_oe,
  output logic [WORD_W-1:0] reg_addr,
  output logic [WORD_W-1:0] reg_wdata,
  output logic              reg_wr,
  output logic              reg_rd,
  output logic              dev_hit,
  output logic              dev_miss
);
  localparam int BYTE_W = 8;
  localparam logic [3:0] BITS = 4'(BYTE_W);

  tws_state_t        st;
  logic [3:0]        bit_cnt;
  logic [7:0]        rx_sr, tx_sr;
  logic [2:0]        idx;      // 0 device, 1 ptr hi, 2 ptr lo, 3 data hi, 4 data lo
  logic              reading, tx_lo, wr_pend;
  logic [WORD_W-1:0] ptr, wdata, rd_word;
  logic              byte_done, dev_ok;

  assign byte_done = (st == ST_RX) && ev_scl_fall && (bit_cnt == BITS);
  assign dev_ok    = dev_match(rx_sr[7:1], addr_sel, DEV_ADDR_0, DEV_ADDR_1);
  assign dev_hit   = byte_done && (idx == 3'd0) && dev_ok;
  assign dev_miss  = byte_done && (idx == 3'd0) && !dev_ok;

  assign reg_addr  = ptr;
  assign reg_wdata = wdata;
  assign reg_wr    = (st == ST_COMMIT);
  assign reg_rd    = (st == ST_FETCH);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      bit_cnt <= '0;
      rx_sr   <= '0;
      tx_sr   <= '0;
      idx     <= '0;
      reading <= 1'b0;
      tx_lo   <= 1'b0;
      wr_pend <= 1'b0;
      ptr     <= '0;
      wdata   <= '0;
      rd_word <= '0;
      sda_oe  <= 1'b0;
    end else if (ev_start) begin
      st      <= ST_RX;
      bit_cnt <= '0;
      idx     <= '0;
      reading <= 1'b0;
      wr_pend <= 1'b0;
      sda_oe  <= 1'b0;
    end else if (ev_stop) begin
      st      <= ST_IDLE;
      reading <= 1'b0;
      wr_pend <= 1'b0;
      sda_oe  <= 1'b0;
    end else begin
      unique case (st)
        ST_RX: begin
          if (ev_scl_rise && bit_cnt < BITS) begin
            rx_sr   <= {rx_sr[6:0], sda_s};
            bit_cnt <= bit_cnt + 4'd1;
          end else if (byte_done) begin
            if (idx == 3'd0) begin
              if (dev_ok) begin
                sda_oe  <= 1'b1;
                reading <= rx_sr[0];
                if (rx_sr[0]) begin
                  st <= ST_FETCH;
                end else begin
                  st  <= ST_ACK;
                  idx <= 3'd1;
                end
              end else begin
                st <= ST_IGNORE;
              end
            end else begin
              sda_oe <= 1'b1;
              st     <= ST_ACK;
              unique case (idx)
                3'd1:    begin ptr[15:8]   <= rx_sr; idx <= 3'd2; end
                3'd2:    begin ptr[7:0]    <= rx_sr; idx <= 3'd3; end
                3'd3:    begin wdata[15:8] <= rx_sr; idx <= 3'd4; end
                default: begin wdata[7:0]  <= rx_sr; idx <= 3'd3; wr_pend <= 1'b1; end
              endcase
            end
          end
        end
        ST_FETCH: begin
          rd_word <= reg_rdata;
          // Entered from the device acknowledge (line held low) or after a master ack.
          st <= sda_oe ? ST_ACK : ST_HOLD;
        end
        ST_ACK: begin
          if (ev_scl_fall) begin
            if (reading) begin
              sda_oe  <= ~word_byte(rd_word, 1'b0)[7];
              tx_sr   <= {word_byte(rd_word, 1'b0)[6:0], 1'b0};
              bit_cnt <= 4'd1;
              tx_lo   <= 1'b0;
              st      <= ST_TX;
            end else begin
              sda_oe  <= 1'b0;
              bit_cnt <= '0;
              st      <= wr_pend ? ST_COMMIT : ST_RX;
            end
          end
        end
        ST_COMMIT: begin
          wr_pend <= 1'b0;
          ptr     <= ptr_step(ptr);
          st      <= ST_RX;
        end
        ST_TX: begin
          if (ev_scl_fall) begin
            if (bit_cnt == BITS) begin
              sda_oe <= 1'b0;
              st     <= ST_MACK;
            end else begin
              sda_oe  <= ~tx_sr[7];
              tx_sr   <= {tx_sr[6:0], 1'b0};
              bit_cnt <= bit_cnt + 4'd1;
            end
          end
        end
        ST_MACK: begin
          if (ev_scl_rise) begin
            if (sda_s) begin
              st <= ST_IGNORE;
            end else if (tx_lo) begin
              ptr <= ptr_step(ptr);
              st  <= ST_FETCH;
            end else begin
              st <= ST_HOLD;
            end
          end
        end
        ST_HOLD: begin
          if (ev_scl_fall) begin
            sda_oe  <= ~word_byte(rd_word, ~tx_lo)[7];
            tx_sr   <= {word_byte(rd_word, ~tx_lo)[6:0], 1'b0};
            bit_cnt <= 4'd1;
            tx_lo   <= ~tx_lo;
            st      <= ST_TX;
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/tws_reg_slave.sv
module tws_reg_slave
  import tws_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR_0  = 7'h48,
  parameter logic [6:0] DEV_ADDR_1  = 7'h5D,
  parameter int         SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        scl_i,
  input  logic        sda_i,
  input  logic        addr_sel,
  output logic        sda_oe,
  output logic [15:0] reg_addr,
  output logic [15:0] reg_wdata,
  output logic        reg_wr,
  output logic        reg_rd,
  input  logic [15:0] reg_rdata
);
  localparam int LINES  = 2;
  localparam int WORD_W = 16;

  logic [LINES-1:0] lines_s;
  logic scl_s, sda_s;
  logic ev_scl_rise, ev_scl_fall, ev_start, ev_stop;
  logic dev_hit, dev_miss;

  tws_line_sync #(.STAGES(SYNC_STAGES), .W(LINES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({scl_i, sda_i}),
    .q     (lines_s)
  );

  assign scl_s = lines_s[1];
  assign sda_s = lines_s[0];

  tws_bus_cond u_cond (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_s    (scl_s),
    .sda_s    (sda_s),
    .scl_rise (ev_scl_rise),
    .scl_fall (ev_scl_fall),
    .start_ev (ev_start),
    .stop_ev  (ev_stop)
  );

  tws_slave_ctrl #(
    .DEV_ADDR_0 (DEV_ADDR_0),
    .DEV_ADDR_1 (DEV_ADDR_1),
    .WORD_W     (WORD_W)
  ) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .sda_s       (sda_s),
    .ev_scl_rise (ev_scl_rise),
    .ev_scl_fall (ev_scl_fall),
    .ev_start    (ev_start),
    .ev_stop     (ev_stop),
    .addr_sel    (addr_sel),
    .reg_rdata   (reg_rdata),
    .sda_oe      (sda_oe),
    .reg_addr    (reg_addr),
    .reg_wdata   (reg_wdata),
    .reg_wr      (reg_wr),
    .reg_rd      (reg_rd),
    .dev_hit     (dev_hit),
    .dev_miss    (dev_miss)
  );
endmodule

// File: rtl/tws_reg_slave_chk.sv
module tws_reg_slave_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        scl_s,
  input logic        sda_oe,
  input logic        reg_wr,
  input logic        reg_rd,
  input logic [15:0] reg_addr,
  input logic        ev_start,
  input logic        ev_stop,
  input logic        dev_hit,
  input logic        dev_miss
);
  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n) !(reg_wr && reg_rd)); // R10
  AST_WR_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n) reg_wr |=> !reg_wr); // R10
  AST_RD_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n) reg_rd |=> !reg_rd); // R10
  AST_PTR_AFTER_WR: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && !ev_start && !ev_stop) |=> reg_addr == $past(reg_addr) + 16'd1); // R6
  AST_STOP_RELEASE: assert property (@(posedge clk) disable iff (!rst_n) ev_stop |=> !sda_oe); // R2
  AST_HIT_ACKS: assert property (@(posedge clk) disable iff (!rst_n)
    (dev_hit && !ev_start && !ev_stop) |=> sda_oe); // R5
  AST_MISS_QUIET: assert property (@(posedge clk) disable iff (!rst_n) dev_miss |=> !sda_oe); // R4
  AST_OE_CLK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(sda_oe) && !$past(ev_start) && !$past(ev_stop)) |-> !scl_s); // R11
endmodule

bind tws_reg_slave tws_reg_slave_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .scl_s    (scl_s),
  .sda_oe   (sda_oe),
  .reg_wr   (reg_wr),
  .reg_rd   (reg_rd),
  .reg_addr (reg_addr),
  .ev_start (ev_start),
  .ev_stop  (ev_stop),
  .dev_hit  (dev_hit),
  .dev_miss (dev_miss)
);

// File: tb/tws_reg_slave_tb.sv
module tws_reg_slave_tb;
  localparam int Q  = 6;
  localparam int WD = 190000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1, addr_sel = 1'b0;
  logic sda_oe, reg_wr, reg_rd;
  logic [15:0] reg_addr, reg_wdata, reg_rdata;
  wire sda_line = sda_m & ~sda_oe;

  int tests = 0, fails = 0;
  bit done = 1'b0;

  logic [15:0] mem [16];
  logic [15:0] wr_a [32];
  logic [15:0] wr_d [32];
  logic [15:0] rd_a [32];
  int wr_n = 0, rd_n = 0, oe_viol = 0, strobe_bad = 0;
  logic prev_oe = 1'b0, prev_scl = 1'b1, prev_wr = 1'b0, prev_rd = 1'b0;

  always #2 clk = ~clk;

  tws_reg_slave u_dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line), .addr_sel(addr_sel),
    .sda_oe(sda_oe), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_rdata(reg_rdata)
  );

  function automatic logic [15:0] finit(input int i);
    return (16'(i) * 16'h1357) ^ 16'hA5C3;
  endfunction

  assign reg_rdata = mem[reg_addr[3:0]];

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 16; i++) mem[i] <= finit(i);
    end else begin
      if (reg_wr) begin
        mem[reg_addr[3:0]] <= reg_wdata;
        wr_a[wr_n[4:0]] <= reg_addr;
        wr_d[wr_n[4:0]] <= reg_wdata;
        wr_n <= wr_n + 1;
      end
      if (reg_rd) begin
        rd_a[rd_n[4:0]] <= reg_addr;
        rd_n <= rd_n + 1;
      end
      if (sda_oe !== prev_oe && scl_m && prev_scl) oe_viol <= oe_viol + 1;
      if ((reg_wr && reg_rd) || (reg_wr && prev_wr) || (reg_rd && prev_rd))
        strobe_bad <= strobe_bad + 1;
    end
    prev_oe  <= sda_oe;
    prev_scl <= scl_m;
    prev_wr  <= reg_wr;
    prev_rd  <= reg_rd;
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic w(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; w(Q); scl_m = 1'b1; w(Q); sda_m = 1'b0; w(Q); scl_m = 1'b0; w(Q);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; w(Q); scl_m = 1'b1; w(Q); sda_m = 1'b1; w(Q);
  endtask

  task automatic send_bit(input logic b);
    sda_m = b; w(Q); scl_m = 1'b1; w(2 * Q); scl_m = 1'b0; w(Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack_n);
    for (int i = 7; i >= 0; i--) send_bit(b[i]);
    sda_m = 1'b1; w(Q); scl_m = 1'b1; w(Q); ack_n = sda_line; w(Q); scl_m = 1'b0; w(Q);
  endtask

  task automatic read_byte(output logic [7:0] b, input logic master_ack);
    b = '0;
    for (int i = 0; i < 8; i++) begin
      sda_m = 1'b1; w(Q); scl_m = 1'b1; w(Q); b = {b[6:0], sda_line}; w(Q); scl_m = 1'b0; w(Q);
    end
    send_bit(~master_ack);
  endtask

  task automatic read_word(output logic [15:0] v, input logic last);
    logic [7:0] hi, lo;
    read_byte(hi, 1'b1);
    read_byte(lo, ~last);
    v = {hi, lo};
  endtask

  initial begin
    repeat (WD) @(posedge clk);
    if (!done) begin
      fails++;
      tests++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic a, any_nack;
    logic [15:0] v;
    int w0, r0;
    w(5);
    chk(sda_oe == 1'b0 && reg_wr == 1'b0 && reg_rd == 1'b0, "R1 reset", {sda_oe, reg_wr, reg_rd}, 0);
    rst_n = 1'b1;
    w(10);

    // R3: every 7-bit address with both strap settings, write direction
    for (int s = 0; s < 2; s++) begin
      addr_sel = s[0];
      w(Q);
      for (int ad = 0; ad < 128; ad++) begin
        logic exp_ack;
        exp_ack = (ad == (s == 0 ? 32'h48 : 32'h5D));
        bus_start();
        send_byte({ad[6:0], 1'b0}, a);
        bus_stop();
        chk((~a) == exp_ack, "R3 address sweep", {s[7:0], ad[7:0], 7'd0, ~a}, exp_ack);
      end
    end
    chk(wr_n == 0 && rd_n == 0, "R3 sweep makes no strobes", wr_n + rd_n, 0);

    // R5 R6: three words starting at 0x0003
    addr_sel = 1'b0; w(Q);
    any_nack = 1'b0;
    bus_start();
    send_byte(8'h90, a); any_nack |= a;
    send_byte(8'h00, a); any_nack |= a;
    send_byte(8'h03, a); any_nack |= a;
    send_byte(8'h12, a); any_nack |= a;
    send_byte(8'h34, a); any_nack |= a;
    send_byte(8'hBE, a); any_nack |= a;
    send_byte(8'hEF, a); any_nack |= a;
    send_byte(8'h0F, a); any_nack |= a;
    send_byte(8'h0F, a); any_nack |= a;
    bus_stop();
    w(4);
    chk(any_nack == 1'b0, "R5 every write byte acked", any_nack, 0);
    chk(wr_n == 3, "R6 word strobe count", wr_n, 3);
    chk(wr_a[0] == 16'h0003 && wr_d[0] == 16'h1234, "R6 word0", {wr_a[0], wr_d[0]}, 32'h00031234);
    chk(wr_a[1] == 16'h0004 && wr_d[1] == 16'hBEEF, "R6 word1", {wr_a[1], wr_d[1]}, 32'h0004BEEF);
    chk(wr_a[2] == 16'h0005 && wr_d[2] == 16'h0F0F, "R6 word2", {wr_a[2], wr_d[2]}, 32'h00050F0F);
    chk(sda_oe == 1'b0, "R2 stop releases line", sda_oe, 0);

    // R6: pointer wrap
    bus_start();
    send_byte(8'h90, a); send_byte(8'hFF, a); send_byte(8'hFF, a);
    send_byte(8'h11, a); send_byte(8'h11, a); send_byte(8'h22, a); send_byte(8'h22, a);
    bus_stop(); w(4);
    chk(wr_n == 5 && wr_a[3] == 16'hFFFF && wr_a[4] == 16'h0000, "R6 pointer wrap",
        {wr_a[3], wr_a[4]}, 32'hFFFF0000);

    // R7: half word then stop
    bus_start();
    send_byte(8'h90, a); send_byte(8'h00, a); send_byte(8'h0A, a); send_byte(8'h77, a);
    bus_stop(); w(4);
    chk(wr_n == 5, "R7 half word no strobe", wr_n, 5);

    // R4 R2: mismatch ignores following bytes until a repeated start
    any_nack = 1'b1;
    bus_start();
    send_byte(8'hBA, a); any_nack &= a;
    send_byte(8'h00, a); any_nack &= a;
    send_byte(8'h02, a); any_nack &= a;
    send_byte(8'h55, a); any_nack &= a;
    send_byte(8'h66, a); any_nack &= a;
    chk(any_nack == 1'b1 && wr_n == 5, "R4 ignored after mismatch", {any_nack, 8'(wr_n)}, {1'b1, 8'd5});
    bus_start();
    send_byte(8'h90, a);
    chk(a == 1'b0, "R2 repeated start reopens address byte", a, 0);
    send_byte(8'h00, a); send_byte(8'h02, a); send_byte(8'hCA, a); send_byte(8'hFE, a);
    bus_stop(); w(4);
    chk(wr_n == 6 && wr_a[5] == 16'h0002 && wr_d[5] == 16'hCAFE, "R2 write after repeated start",
        {wr_a[5], wr_d[5]}, 32'h0002CAFE);

    // R8 R9: strap high, pointer 7, repeated start, three-word read
    addr_sel = 1'b1; w(Q);
    r0 = rd_n; w0 = wr_n;
    bus_start();
    send_byte(8'hBA, a); send_byte(8'h00, a); send_byte(8'h07, a);
    bus_start();
    send_byte(8'hBB, a);
    chk(a == 1'b0, "R3 read address acked", a, 0);
    read_word(v, 1'b0); chk(v == finit(7), "R8 first word", v, finit(7));
    read_word(v, 1'b0); chk(v == finit(8), "R9 second word", v, finit(8));
    read_word(v, 1'b1); chk(v == finit(9), "R9 third word", v, finit(9));
    bus_stop(); w(4);
    chk(rd_n - r0 == 3 && rd_a[r0[4:0]] == 16'h7 && rd_a[r0[4:0] + 5'd2] == 16'h9, "R9 fetch addresses",
        rd_n - r0, 3);
    chk(wr_n == w0, "R7 pointer-only write no strobe", wr_n, w0);

    // R9: not-acknowledge left the pointer at 9
    bus_start();
    send_byte(8'hBB, a);
    read_word(v, 1'b1);
    bus_stop(); w(4);
    chk(v == finit(9), "R9 NACK no increment", v, finit(9));

    // R7: address 0x000A untouched by the half word
    bus_start();
    send_byte(8'hBA, a); send_byte(8'h00, a); send_byte(8'h0A, a);
    bus_start();
    send_byte(8'hBB, a);
    read_word(v, 1'b1);
    bus_stop(); w(4);
    chk(v == finit(10), "R7 half word left register", v, finit(10));

    chk(oe_viol == 0, "R11 line changes only with clock low", oe_viol, 0);
    chk(strobe_bad == 0, "R10 strobes exclusive single cycle", strobe_bad, 0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule